// File: doc/BRIEF.md
# Disk Command Issue Sequencer

This block sits on the host side of an old-style polled disk controller. It takes one read or write request and drives it to completion over a byte-wide port bus. A request carries a logical block number, a sector count, a drive number, a per-drive control byte and the number of heads on that drive. The block splits the block number into cylinder, head and sector using an iterative divider. It packs the six-byte command. It performs the select handshake and hands the bytes over one at a time, checking the controller's handshake bits before each one. It then waits for the completion byte and reads it.

Every poll loop is bounded. When a loop runs out, the command ends with an error and a sticky flag tells the host that the controller must be reset. The host can also present the error code returned by a later sense command. The block then reports whether the error can be corrected in place or whether the controller needs a reset. Retry policy and the DMA engine are left to the surrounding logic.

Top module: `dcs_seq`

## Requirements
- R1: A request is taken only while `req_ready` is high, which is only in the idle state. A request raised while a command is in progress is ignored: it issues no port access and does not alter the command bytes.
- R2: With 17 sectors per track and S = heads × 17, the block computes cylinder = block / S, head = (block mod S) / 17 and sector = block mod 17.
- R3: Command byte 0 is 0x08 for a read (`req_write`=0) and 0x0A for a write.
- R4: Byte 1 is head OR (drive << 5). Byte 2 holds cylinder bits 9:8 in bits 7:6 and the sector in bits 5:0. Byte 3 is cylinder bits 7:0.
- R5: Byte 4 is the sector count and byte 5 is the control byte. The six bytes are written to port address 0 (data) in order 0 to 5.
- R6: A command starts by writing 0x03 to port address 3 (mode), then 0x03 to port address 2 (select). The block then reads port address 1 (status) until bit 3 (BUSY) is set. At most one port access occurs per cycle.
- R7: Before each command byte the block reads status until bit 0 (REQ) is set. That status must also show bit 3 (BUSY) and bit 2 (command phase) set and bit 1 (input) clear. Otherwise the command ends at once with an error, and `need_reset` is left unchanged.
- R8: Every poll loop gives up after POLL_LIMIT status reads that did not succeed. Giving up ends the command with an error and sets `need_reset`. `need_reset` stays set until `nr_clr` is pulsed.
- R9: After the sixth byte, the block reads status until REQ and input (bits 0 and 1) are both set. It then reads the data port once and presents that byte on `stat_byte`. If bit 1 of that byte is set, `ok`=0 and `sense_req`=1. `done` is high for exactly one cycle, in the first idle cycle.
- R10: In idle, `sense_vld` classifies `sense_code`. If its low six bits equal 24, `ecc_fix` is set. If they are any other nonzero value, `need_reset` is set. If they are zero, neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_block | input | BLK_W | Logical block number |
| req_count | input | 8 | Sector count |
| req_drive | input | 3 | Drive number |
| req_ctl | input | 8 | Per-drive control byte |
| req_heads | input | HEAD_W | Heads on the drive (nonzero) |
| sense_vld | input | 1 | Sense code presented |
| sense_code | input | 8 | Sense error code |
| nr_clr | input | 1 | Clears need_reset |
| req_ready | output | 1 | Idle, request accepted |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result of the last command |
| sense_req | output | 1 | Completion byte flagged an error |
| ecc_fix | output | 1 | Last sense code was correctable |
| need_reset | output | 1 | Sticky controller reset request |
| stat_byte | output | 8 | Completion byte |
| prt_rd | output | 1 | Port read strobe |
| prt_wr | output | 1 | Port write strobe |
| prt_addr | output | 2 | Port address |
| prt_wdata | output | 8 | Port write data |
| prt_rdata | input | 8 | Port read data, valid while prt_rd is high |

## Verification
The bench builds the block with POLL_LIMIT set to 8 and keeps the default widths. This makes every timeout reachable within a few cycles, on both sides of the limit, for both the BUSY wait and the completion wait. It sweeps head counts 1 to 4 against block numbers at track and cylinder edges, up to the largest 10-bit cylinder. It compares all six captured bytes against values it computes arithmetically. A behavioural controller model covers the remaining cases: late BUSY, a wrong phase mid-command, an error completion byte, and the three classes of sense code.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int ST_REQ = 0;
    localparam int ST_IN  = 1;
    localparam int ST_CMD = 2;
    localparam int ST_BSY = 3;
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_SEL  = 2'd2;
    localparam logic [1:0] A_MODE = 2'd3;
    localparam logic [7:0] OP_READ  = 8'h08;
    localparam logic [7:0] OP_WRITE = 8'h0A;
    localparam logic [7:0] MODE_XFER = 8'h03;
    localparam logic [5:0] ECC_CODE = 6'd24;

    typedef enum logic [3:0] {
        S_IDLE, S_DIV1, S_DIV2, S_SEL, S_BRD, S_BEV,
        S_QRD, S_QEV, S_CRD, S_CEV, S_SRD, S_SEV
    } seq_st_e;
endpackage

// File: rtl/dcs_div.sv
module dcs_div #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic          done;
    } div_t;

    div_t q, n;
    logic [W:0] trial;
    logic       take;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        trial  = {q.rem, q.quo[W-1]};
        take   = (trial >= {1'b0, dvs});
        if (go) begin
            n.busy = 1'b1;
            n.cnt  = '0;
            n.rem  = '0;
            n.quo  = dvd;
        end else if (q.busy) begin
            if (take) trial = trial - {1'b0, dvs};
            n.rem = trial[W-1:0];
            n.quo = {q.quo[W-2:0], take};
            n.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(W - 1)) begin
                n.busy = 1'b0;
                n.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign quo  = q.quo;
    assign rem  = q.rem;
    assign done = q.done;
endmodule

// File: rtl/dcs_pack.sv
module dcs_pack #(
    parameter int HEAD_W = 5,
    parameter int CYL_W  = 10
) (
    input  logic              wr_op,
    input  logic [CYL_W-1:0]  cyl,
    input  logic [HEAD_W-1:0] head,
    input  logic [5:0]        sect,
    input  logic [7:0]        cnt,
    input  logic [2:0]        drv,
    input  logic [7:0]        ctl,
    output logic [5:0][7:0]   bytes
);
    import dcs_pkg::*;

    always_comb begin
        bytes[0] = wr_op ? OP_WRITE : OP_READ;
        bytes[1] = 8'(head) | {drv, 5'b0};
        bytes[2] = {cyl[9:8], sect};
        bytes[3] = cyl[7:0];
        bytes[4] = cnt;
        bytes[5] = ctl;
    end
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq #(
    parameter int BLK_W      = 21,
    parameter int HEAD_W     = 5,
    parameter int SPT        = 17,
    parameter int POLL_LIMIT = 32000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BLK_W-1:0]  req_block,
    input  logic [7:0]        req_count,
    input  logic [2:0]        req_drive,
    input  logic [7:0]        req_ctl,
    input  logic [HEAD_W-1:0] req_heads,
    input  logic              sense_vld,
    input  logic [7:0]        sense_code,
    input  logic              nr_clr,
    output logic              req_ready,
    output logic              done,
    output logic              ok,
    output logic              sense_req,
    output logic              ecc_fix,
    output logic              need_reset,
    output logic [7:0]        stat_byte,
    output logic              prt_rd,
    output logic              prt_wr,
    output logic [1:0]        prt_addr,
    output logic [7:0]        prt_wdata,
    input  logic [7:0]        prt_rdata
);
    import dcs_pkg::*;

    localparam int CYL_W = 10;
    localparam int PC_W  = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        seq_st_e           st;
        logic              wr_op;
        logic [BLK_W-1:0]  dvd;
        logic [BLK_W-1:0]  dvs;
        logic              go;
        logic [CYL_W-1:0]  cyl;
        logic [HEAD_W-1:0] head;
        logic [5:0]        sect;
        logic [7:0]        cnt;
        logic [2:0]        drv;
        logic [7:0]        ctl;
        logic [PC_W-1:0]   pc;
        logic [2:0]        idx;
        logic              rd;
        logic              wr;
        logic [1:0]        addr;
        logic [7:0]        wdata;
        logic              done;
        logic              ok;
        logic              sense;
        logic              ecc;
        logic              nr;
        logic [7:0]        stat;
    } seq_t;

    seq_t q, n;
    logic [BLK_W-1:0] div_quo, div_rem;
    logic             div_done;
    logic [5:0][7:0]  cmd;
    logic             pfail;
    seq_st_e          pback;
    logic             phase_ok;

    dcs_div #(.W(BLK_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(q.go), .dvd(q.dvd), .dvs(q.dvs),
        .quo(div_quo), .rem(div_rem), .done(div_done)
    );

    dcs_pack #(.HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_pack (
        .wr_op(q.wr_op), .cyl(q.cyl), .head(q.head), .sect(q.sect),
        .cnt(q.cnt), .drv(q.drv), .ctl(q.ctl), .bytes(cmd)
    );

    always_comb begin
        n        = q;
        n.go     = 1'b0;
        n.rd     = 1'b0;
        n.wr     = 1'b0;
        n.done   = 1'b0;
        pfail    = 1'b0;
        pback    = S_IDLE;
        phase_ok = prt_rdata[ST_BSY] && prt_rdata[ST_CMD] && !prt_rdata[ST_IN];
        if (nr_clr) n.nr = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    n.wr_op = req_write;
                    n.cnt   = req_count;
                    n.drv   = req_drive;
                    n.ctl   = req_ctl;
                    n.dvd   = req_block;
                    n.dvs   = BLK_W'(req_heads * SPT);
                    n.go    = 1'b1;
                    n.ok    = 1'b0;
                    n.sense = 1'b0;
                    n.ecc   = 1'b0;
                    n.stat  = '0;
                    n.st    = S_DIV1;
                end else if (sense_vld) begin
                    n.ecc = (sense_code[5:0] == ECC_CODE);
                    if (sense_code[5:0] != ECC_CODE && sense_code[5:0] != 6'd0)
                        n.nr = 1'b1;
                end
            end
            S_DIV1: if (div_done) begin
                n.cyl = div_quo[CYL_W-1:0];
                n.dvd = div_rem;
                n.dvs = BLK_W'(SPT);
                n.go  = 1'b1;
                n.st  = S_DIV2;
            end
            S_DIV2: if (div_done) begin
                n.head  = div_quo[HEAD_W-1:0];
                n.sect  = div_rem[5:0];
                n.wr    = 1'b1;
                n.addr  = A_MODE;
                n.wdata = MODE_XFER;
                n.st    = S_SEL;
            end
            S_SEL: begin
                n.wr    = 1'b1;
                n.addr  = A_SEL;
                n.wdata = MODE_XFER;
                n.pc    = '0;
                n.st    = S_BRD;
            end
            S_BRD, S_QRD, S_CRD: begin
                n.rd   = 1'b1;
                n.addr = A_STAT;
                n.st   = (q.st == S_BRD) ? S_BEV : (q.st == S_QRD) ? S_QEV : S_CEV;
            end
            S_BEV: begin
                if (prt_rdata[ST_BSY]) begin
                    n.pc  = '0;
                    n.idx = '0;
                    n.st  = S_QRD;
                end else begin
                    pfail = 1'b1;
                    pback = S_BRD;
                end
            end
            S_QEV: begin
                if (!prt_rdata[ST_REQ]) begin
                    pfail = 1'b1;
                    pback = S_QRD;
                end else if (phase_ok) begin
                    n.wr    = 1'b1;
                    n.addr  = A_DATA;
                    n.wdata = cmd[q.idx];
                    n.pc    = '0;
                    n.idx   = q.idx + 1'b1;
                    n.st    = (q.idx == 3'd5) ? S_CRD : S_QRD;
                end else begin
                    n.done = 1'b1;
                    n.ok   = 1'b0;
                    n.st   = S_IDLE;
                end
            end
            S_CEV: begin
                if (prt_rdata[ST_REQ] && prt_rdata[ST_IN]) begin
                    n.st = S_SRD;
                end else begin
                    pfail = 1'b1;
                    pback = S_CRD;
                end
            end
            S_SRD: begin
                n.rd   = 1'b1;
                n.addr = A_DATA;
                n.st   = S_SEV;
            end
            S_SEV: begin
                n.stat  = prt_rdata;
                n.ok    = !prt_rdata[1];
                n.sense = prt_rdata[1];
                n.done  = 1'b1;
                n.st    = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase
        if (pfail) begin
            if (q.pc == PC_W'(POLL_LIMIT - 1)) begin
                n.done = 1'b1;
                n.ok   = 1'b0;
                n.nr   = 1'b1;
                n.st   = S_IDLE;
            end else begin
                n.pc = q.pc + 1'b1;
                n.st = pback;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= n;
    end

    assign req_ready  = (q.st == S_IDLE);
    assign done       = q.done;
    assign ok         = q.ok;
    assign sense_req  = q.sense;
    assign ecc_fix    = q.ecc;
    assign need_reset = q.nr;
    assign stat_byte  = q.stat;
    assign prt_rd     = q.rd;
    assign prt_wr     = q.wr;
    assign prt_addr   = q.addr;
    assign prt_wdata  = q.wdata;
endmodule

// File: rtl/dcs_chk.sv
module dcs_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic ok,
    input logic sense_req,
    input logic need_reset,
    input logic nr_clr,
    input logic prt_rd,
    input logic prt_wr
);
    // R1: no port write is issued while idle
    p_no_idle_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        prt_wr |-> !req_ready);
    // R6: one access per cycle
    p_single_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(prt_rd && prt_wr));
    // R8: sticky flag
    p_nr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (need_reset && !nr_clr) |=> need_reset);
    // R9: done only in idle, one cycle wide
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_sense_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sense_req) |-> !ok);
endmodule

bind dcs_seq dcs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .ok(ok),
    .sense_req(sense_req), .need_reset(need_reset), .nr_clr(nr_clr),
    .prt_rd(prt_rd), .prt_wr(prt_wr)
);

// File: tb/dcs_seq_tb.sv
module dcs_seq_tb;
    localparam int BLK_W = 21;
    localparam int HEAD_W = 5;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [BLK_W-1:0] req_block = '0;
    logic [7:0] req_count = '0, req_ctl = '0, sense_code = '0;
    logic [2:0] req_drive = '0;
    logic [HEAD_W-1:0] req_heads = 5'd1;
    logic sense_vld = 1'b0, nr_clr = 1'b0;
    logic req_ready, done, ok, sense_req, ecc_fix, need_reset;
    logic [7:0] stat_byte, prt_wdata, prt_rdata;
    logic prt_rd, prt_wr;
    logic [1:0] prt_addr;

    int errs = 0, checks = 0, cyc = 0;
    int phase = 0, nreads = 0, nb = 0, wr_total = 0;
    int busy_after = 0, cmp_after = 2, bad_at = -1;
    logic [7:0] stat_val = 8'h00;
    logic [7:0] cap [6];
    logic [1:0] la [8];
    logic [7:0] lv [8];

    always #5 clk = ~clk;

    dcs_seq #(.BLK_W(BLK_W), .HEAD_W(HEAD_W), .SPT(17), .POLL_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_block(req_block), .req_count(req_count), .req_drive(req_drive),
        .req_ctl(req_ctl), .req_heads(req_heads), .sense_vld(sense_vld),
        .sense_code(sense_code), .nr_clr(nr_clr), .req_ready(req_ready),
        .done(done), .ok(ok), .sense_req(sense_req), .ecc_fix(ecc_fix),
        .need_reset(need_reset), .stat_byte(stat_byte), .prt_rd(prt_rd),
        .prt_wr(prt_wr), .prt_addr(prt_addr), .prt_wdata(prt_wdata),
        .prt_rdata(prt_rdata)
    );

    // behavioural controller
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (req_valid && req_ready) begin
            phase <= 0; nreads <= 0; nb <= 0; wr_total <= 0;
        end else begin
            if (prt_wr) begin
                if (wr_total < 8) begin
                    la[wr_total] <= prt_addr;
                    lv[wr_total] <= prt_wdata;
                end
                wr_total <= wr_total + 1;
                if (prt_addr == 2'd2) begin
                    phase <= 1; nreads <= 0; nb <= 0;
                end else if (prt_addr == 2'd0 && phase == 1) begin
                    cap[nb] <= prt_wdata;
                    nb <= nb + 1;
                    if (nb == 5) begin phase <= 2; nreads <= 0; end
                end
            end
            if (prt_rd && prt_addr == 2'd1) nreads <= nreads + 1;
        end
    end

    always_comb begin
        prt_rdata = 8'h00;
        if (prt_addr == 2'd0) prt_rdata = stat_val;
        else if (prt_addr == 2'd1) begin
            if (phase == 1)
                prt_rdata = (nreads < busy_after) ? 8'h00 : (nb == bad_at) ? 8'h0F : 8'h0D;
            else if (phase == 2)
                prt_rdata = (nreads < cmp_after) ? 8'h08 : 8'h0B;
        end
    end

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit w, input int blk, input int cnt, input int drv,
                         input int ctl, input int hds);
        @(negedge clk);
        req_write = w; req_block = BLK_W'(blk); req_count = 8'(cnt);
        req_drive = 3'(drv); req_ctl = 8'(ctl); req_heads = HEAD_W'(hds);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic check_bytes(input bit w, input int blk, input int cnt, input int drv,
                               input int ctl, input int hds);
        int spc = hds * 17;
        int cyl = blk / spc;
        int hd = (blk % spc) / 17;
        int sc = blk % 17;
        logic [7:0] e [6];
        e[0] = w ? 8'h0A : 8'h08;
        e[1] = 8'(hd | (drv << 5));
        e[2] = 8'(((cyl >> 8) << 6) | sc);
        e[3] = 8'(cyl & 255);
        e[4] = 8'(cnt);
        e[5] = 8'(ctl);
        chk(nb == 6, "R5 byte count", nb, 6);
        chk(cap[0] == e[0], "R3 opcode", cap[0], e[0]);
        chk(cap[1] == e[1], "R2 R4 head/drive", cap[1], e[1]);
        chk(cap[2] == e[2], "R2 R4 cylhi/sector", cap[2], e[2]);
        chk(cap[3] == e[3], "R2 R4 cyl low", cap[3], e[3]);
        chk(cap[4] == e[4] && cap[5] == e[5], "R5 count/ctl",
            {cap[4], cap[5]}, {e[4], e[5]});
    endtask

    task automatic pulse_clr();
        @(negedge clk); nr_clr = 1'b1;
        @(negedge clk); nr_clr = 1'b0;
    endtask

    task automatic sense(input int code);
        @(negedge clk); sense_vld = 1'b1; sense_code = 8'(code);
        @(negedge clk); sense_vld = 1'b0;
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks + 1);
            $finish;
        end
    end

    initial begin
        int blks [9];
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !need_reset && !prt_rd && !prt_wr,
            "reset state R1", {req_ready, done, need_reset, prt_rd, prt_wr}, 5'b10000);

        // R2..R5 sweep
        k = 0;
        for (int h = 1; h <= 4; h++) begin
            blks[0] = 0; blks[1] = 1; blks[2] = 16; blks[3] = 17; blks[4] = 18;
            blks[5] = h * 17 - 1; blks[6] = h * 17; blks[7] = h * 17 * 5 + 9;
            blks[8] = h * 17 * 1024 - 1;
            for (int i = 0; i < 9; i++) begin
                issue(k[0], blks[i], k + 1, k % 8, 8'h05 + k, h);
                wait_done();
                chk(ok && !sense_req, "R9 ok result", ok, 1);
                check_bytes(k[0], blks[i], k + 1, k % 8, 8'h05 + k, h);
                k++;
            end
        end

        // R6 mode then select writes
        issue(1'b0, 40, 2, 1, 3, 2);
        wait_done();
        chk(la[0] == 2'd3 && lv[0] == 8'h03, "R6 mode write", {la[0], lv[0]}, {2'd3, 8'h03});
        chk(la[1] == 2'd2 && lv[1] == 8'h03, "R6 select write", {la[1], lv[1]}, {2'd2, 8'h03});

        // R1 request while busy is ignored
        busy_after = 3;
        issue(1'b1, 100, 4, 2, 9, 3);
        repeat (5) @(negedge clk);
        issue(1'b0, 7, 1, 0, 1, 1);
        wait_done();
        check_bytes(1'b1, 100, 4, 2, 9, 3);
        k = wr_total;
        repeat (60) @(negedge clk);
        chk(wr_total == k && req_ready, "R1 busy request ignored", wr_total, k);

        // R8 busy poll limit
        busy_after = LIM - 1;
        issue(1'b0, 5, 1, 0, 0, 1); wait_done();
        chk(ok && !need_reset, "R8 busy at last read", {ok, need_reset}, 2'b10);
        busy_after = LIM;
        issue(1'b0, 5, 1, 0, 0, 1); wait_done();
        chk(!ok && need_reset && nb == 0, "R8 busy timeout", {ok, need_reset}, 2'b01);
        busy_after = 0;
        issue(1'b0, 5, 1, 0, 0, 1); wait_done();
        chk(ok && need_reset, "R8 flag sticky", {ok, need_reset}, 2'b11);
        pulse_clr();
        chk(!need_reset, "R8 clear", need_reset, 0);

        // R8 completion poll limit
        cmp_after = LIM;
        issue(1'b1, 6, 1, 0, 0, 1); wait_done();
        chk(!ok && need_reset && nb == 6, "R8 completion timeout", {ok, need_reset}, 2'b01);
        pulse_clr();
        cmp_after = LIM - 1;
        issue(1'b1, 6, 1, 0, 0, 1); wait_done();
        chk(ok && !need_reset, "R8 completion at last read", {ok, need_reset}, 2'b10);
        cmp_after = 2;

        // R7 wrong phase
        bad_at = 3;
        issue(1'b0, 9, 1, 0, 0, 1); wait_done();
        chk(!ok && nb == 3 && !need_reset, "R7 phase abort", nb, 3);
        bad_at = -1;

        // R9 completion byte
        stat_val = 8'h02;
        issue(1'b0, 9, 1, 0, 0, 1); wait_done();
        chk(!ok && sense_req && stat_byte == 8'h02 && !need_reset, "R9 error byte", stat_byte, 8'h02);
        stat_val = 8'h01;
        issue(1'b0, 9, 1, 0, 0, 1); wait_done();
        chk(ok && !sense_req && stat_byte == 8'h01, "R9 bit1 only", {ok, sense_req}, 2'b10);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        stat_val = 8'h00;

        // R10 sense classification
        sense(8'h58);
        chk(ecc_fix && !need_reset, "R10 ecc code", {ecc_fix, need_reset}, 2'b10);
        sense(8'h00);
        chk(!ecc_fix && !need_reset, "R10 zero code", {ecc_fix, need_reset}, 2'b00);
        sense(8'h19);
        chk(!ecc_fix && need_reset, "R10 other code", {ecc_fix, need_reset}, 2'b01);
        pulse_clr();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule